// File: doc/BRIEF.md
# Audio Serial Clock Ratio Generator

This block turns one internal audio clock into the three timing signals of a serial audio port. The internal clock runs at a fixed multiple of the sample rate fs, and that multiple is either 512 or 384. The three signals are the master-clock enable, the bit-clock enable and the frame (left/right) clock. All three come from a single sample-frame phase counter, so their edges stay aligned. The master clock and the bit clock leave the block as one-cycle enable pulses, which clock-enable logic downstream uses. The frame clock leaves as a level: it is low for the first half of each sample frame and high for the second half. Sample rates from 8 kHz to 192 kHz are covered by choosing the internal clock frequency. That choice is made outside this block.

The configuration has four parts. `mclk_use_i` says whether a master clock is wanted. `base_sel_i` chooses the base family, 0 for 512·fs and 1 for 384·fs. A 3-bit ratio code `ratio_code_i` divides the base down to the master-clock rate. A run request `run_i` and a hard clock gate `gate_i` control the outputs. A sequencer with the states IDLE, RUN, DRAIN and FAULT starts the outputs only on a run request. It takes in a new configuration only at a sample-frame boundary. When the run request drops, it finishes the current frame before going quiet. An illegal ratio code parks it in FAULT.

The sequencer has the following transitions:
- IDLE→RUN on a run request with the gate clear and a legal configuration.
- IDLE→FAULT on a run request with the gate clear and an illegal configuration.
- RUN→DRAIN when the run request drops in the middle of a frame.
- DRAIN→RUN when the run request returns in the middle of a frame.
- RUN/DRAIN→RUN at the frame end if the run request is high and the configuration is legal.
- RUN/DRAIN→FAULT at the frame end if the run request is high and the configuration is illegal.
- RUN/DRAIN→IDLE at the frame end if the run request is low.
- RUN/DRAIN→IDLE at any time when the gate is set.
- FAULT→IDLE when the run request drops or the gate is set.

Top module: `audclk_gen`

## Requirements
- R1: While reset is held and right after it, `mclk_en_o`, `bclk_en_o`, `lrclk_o` and `cfg_err_o` are all 0.
- R2: When the master clock is in use, the frame length is 512 internal cycles with `base_sel_i`=0 and 384 with `base_sel_i`=1. `lrclk_o` is 0 for phases 0 to half−1 of each frame and 1 for phases half to end, so it rises exactly once per frame.
- R3: When `mclk_use_i`=0, the frame is always 512 cycles whatever `base_sel_i` is, `mclk_en_o` stays 0, and no ratio code is treated as illegal.
- R4: With ratio code c, `mclk_en_o` pulses at every frame phase that is a multiple of 2^c. The legal codes are 0 to 4 in the 512 family (512, 256, 128, 64 and 32·fs) and 0 to 3 in the 384 family (384, 192, 96 and 48·fs).
- R5: A configuration with the master clock in use and code 5–7 (512 family) or code 4–7 (384 family) puts the block in FAULT at start. In FAULT, `cfg_err_o`=1 and all clock outputs are 0. FAULT is left when `run_i` drops or `gate_i` is set.
- R6: `bclk_en_o` pulses at every frame phase that is a multiple of 8. This gives 64 bit clocks per frame in the 512 family and 48 in the 384 family.
- R7: One cycle after `run_i` is sampled high with `gate_i` low and a legal configuration, the outputs show frame phase 0: `bclk_en_o`=1, `mclk_en_o`=1 if the master clock is in use, and `lrclk_o`=0.
- R8: If `run_i` drops in the middle of a frame, the outputs carry on to the end of that frame and are all 0 from the following cycle. If `run_i` returns before the frame ends, the frame runs on without a restart and the next frame follows.
- R9: `gate_i` sampled high makes every clock output 0 in the next cycle and discards the frame. The next start begins at phase 0.
- R10: Changes to `mclk_use_i`, `base_sel_i` or `ratio_code_i` while running take effect only at the next frame boundary. An illegal configuration found there moves the block to FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal audio clock (512·fs or 384·fs) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request |
| gate_i | input | 1 | Hard clock gate, stops output immediately |
| mclk_use_i | input | 1 | Master clock output wanted |
| base_sel_i | input | 1 | Base family: 0 = 512·fs, 1 = 384·fs |
| ratio_code_i | input | 3 | Master-clock divide code (divide by 2^code) |
| mclk_en_o | output | 1 | Master-clock enable pulse |
| bclk_en_o | output | 1 | Bit-clock enable pulse |
| lrclk_o | output | 1 | Frame clock level |
| cfg_err_o | output | 1 | Illegal ratio configuration |

## Verification
The assertions assume that `gate_i` and `run_i` are ordinary synchronous levels sampled at the internal clock edge. They also assume the divide-by-8 bit clock, so that two bit-clock pulses can never be adjacent. They do not assume that the ratio code is legal. The stimulus changes every input only on the falling clock edge. The random phase draws codes from the full 3-bit range, with the gate set rarely, so that illegal codes, gating in the middle of a frame and drains are all reached.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Sequencer states of the frame generator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FAULT = 2'd3
    } gen_state_e;

endpackage

// File: rtl/audclk_cfg_decode.sv
module audclk_cfg_decode #(
    parameter int BASE_HI     = 512,
    parameter int BASE_LO     = 384,
    parameter int MCLK_MIN_HI = 32,
    parameter int MCLK_MIN_LO = 48,
    parameter int CODE_W      = 3,
    localparam int PH_W       = $clog2(BASE_HI)
) (
    input  logic              use_i,
    input  logic              sel_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              legal_o,
    output logic [PH_W-1:0]   last_o,
    output logic [PH_W-1:0]   half_o,
    output logic [CODE_W-1:0] shift_o,
    output logic              use_o
);

    localparam int MAXC_HI = $clog2(BASE_HI / MCLK_MIN_HI);
    localparam int MAXC_LO = $clog2(BASE_LO / MCLK_MIN_LO);
    localparam logic [CODE_W-1:0] MAXC_HI_V = CODE_W'(MAXC_HI);
    localparam logic [CODE_W-1:0] MAXC_LO_V = CODE_W'(MAXC_LO);
    localparam logic [PH_W-1:0]   LAST_HI   = PH_W'(BASE_HI - 1);
    localparam logic [PH_W-1:0]   LAST_LO   = PH_W'(BASE_LO - 1);
    localparam logic [PH_W-1:0]   HALF_HI   = PH_W'(BASE_HI / 2);
    localparam logic [PH_W-1:0]   HALF_LO   = PH_W'(BASE_LO / 2);

    logic              lo_fam;
    logic [CODE_W-1:0] max_code;

    always_comb begin
        // without a master clock the 512 family is forced
        lo_fam   = use_i & sel_i;
        max_code = lo_fam ? MAXC_LO_V : MAXC_HI_V;
        legal_o  = !use_i || (code_i <= max_code);
        last_o   = lo_fam ? LAST_LO : LAST_HI;
        half_o   = lo_fam ? HALF_LO : HALF_HI;
        shift_o  = use_i ? code_i : '0;
        use_o    = use_i;
    end

endmodule

// File: rtl/audclk_seq.sv
module audclk_seq
    import audclk_pkg::*;
#(
    parameter int BASE_HI = 512,
    parameter int CODE_W  = 3,
    localparam int PH_W   = $clog2(BASE_HI)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              gate_i,
    input  logic              legal_i,
    input  logic [PH_W-1:0]   last_i,
    input  logic [PH_W-1:0]   half_i,
    input  logic [CODE_W-1:0] shift_i,
    input  logic              use_i,
    output gen_state_e        state_d_o,
    output logic [PH_W-1:0]   ph_d_o,
    output logic [PH_W-1:0]   half_d_o,
    output logic [CODE_W-1:0] shift_d_o,
    output logic              use_d_o
);

    gen_state_e        st_q, st_d;
    logic [PH_W-1:0]   ph_q, ph_d;
    logic [PH_W-1:0]   last_q, last_d;
    logic [PH_W-1:0]   half_q, half_d;
    logic [CODE_W-1:0] shift_q, shift_d;
    logic              use_q, use_d;
    logic              wrap;

    // state register and latched frame configuration
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= ST_IDLE;
            ph_q    <= '0;
            last_q  <= '1;
            half_q  <= '0;
            shift_q <= '0;
            use_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            ph_q    <= ph_d;
            last_q  <= last_d;
            half_q  <= half_d;
            shift_q <= shift_d;
            use_q   <= use_d;
        end
    end

    // next-state logic; configuration loads only at frame start
    always_comb begin
        st_d    = st_q;
        ph_d    = ph_q;
        last_d  = last_q;
        half_d  = half_q;
        shift_d = shift_q;
        use_d   = use_q;
        wrap    = (ph_q == last_q);
        unique case (st_q)
            ST_IDLE: begin
                ph_d = '0;
                if (run_i && !gate_i) begin
                    if (legal_i) begin
                        st_d    = ST_RUN;
                        last_d  = last_i;
                        half_d  = half_i;
                        shift_d = shift_i;
                        use_d   = use_i;
                    end else begin
                        st_d = ST_FAULT;
                    end
                end
            end
            ST_RUN, ST_DRAIN: begin
                if (gate_i) begin
                    st_d = ST_IDLE;
                    ph_d = '0;
                end else if (wrap) begin
                    ph_d = '0;
                    if (!run_i) begin
                        st_d = ST_IDLE;
                    end else if (!legal_i) begin
                        st_d = ST_FAULT;
                    end else begin
                        st_d    = ST_RUN;
                        last_d  = last_i;
                        half_d  = half_i;
                        shift_d = shift_i;
                        use_d   = use_i;
                    end
                end else begin
                    ph_d = ph_q + 1'b1;
                    st_d = run_i ? ST_RUN : ST_DRAIN;
                end
            end
            ST_FAULT: begin
                ph_d = '0;
                if (!run_i || gate_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign state_d_o = st_d;
    assign ph_d_o    = ph_d;
    assign half_d_o  = half_d;
    assign shift_d_o = shift_d;
    assign use_d_o   = use_d;

endmodule

// File: rtl/audclk_out_stage.sv
module audclk_out_stage
    import audclk_pkg::*;
#(
    parameter int BASE_HI  = 512,
    parameter int CODE_W   = 3,
    parameter int BCLK_DIV = 8,
    localparam int PH_W    = $clog2(BASE_HI),
    localparam int BCLK_SH = $clog2(BCLK_DIV)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  gen_state_e        state_d_i,
    input  logic [PH_W-1:0]   ph_d_i,
    input  logic [PH_W-1:0]   half_d_i,
    input  logic [CODE_W-1:0] shift_d_i,
    input  logic              use_d_i,
    output logic              mclk_en_o,
    output logic              bclk_en_o,
    output logic              lrclk_o,
    output logic              cfg_err_o
);

    logic            active;
    logic            bclk_hit;
    logic            mclk_hit;
    logic [PH_W-1:0] mclk_mask;

    assign active    = (state_d_i == ST_RUN) || (state_d_i == ST_DRAIN);
    assign mclk_mask = ~({PH_W{1'b1}} << shift_d_i);
    assign mclk_hit  = ((ph_d_i & mclk_mask) == '0);

    generate
        if (BCLK_SH == 0) begin : g_bclk_full
            assign bclk_hit = 1'b1;
        end else begin : g_bclk_div
            assign bclk_hit = (ph_d_i[BCLK_SH-1:0] == '0);
        end
    endgenerate

    // output registers loaded from next state: no decode glitches reach pins
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mclk_en_o <= 1'b0;
            bclk_en_o <= 1'b0;
            lrclk_o   <= 1'b0;
            cfg_err_o <= 1'b0;
        end else begin
            mclk_en_o <= active && use_d_i && mclk_hit;
            bclk_en_o <= active && bclk_hit;
            lrclk_o   <= active && (ph_d_i >= half_d_i);
            cfg_err_o <= (state_d_i == ST_FAULT);
        end
    end

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int BASE_HI     = 512,
    parameter int BASE_LO     = 384,
    parameter int MCLK_MIN_HI = 32,
    parameter int MCLK_MIN_LO = 48,
    parameter int BCLK_DIV    = 8,
    parameter int CODE_W      = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              gate_i,
    input  logic              mclk_use_i,
    input  logic              base_sel_i,
    input  logic [CODE_W-1:0] ratio_code_i,
    output logic              mclk_en_o,
    output logic              bclk_en_o,
    output logic              lrclk_o,
    output logic              cfg_err_o
);

    localparam int PH_W = $clog2(BASE_HI);

    logic              dec_legal;
    logic [PH_W-1:0]   dec_last;
    logic [PH_W-1:0]   dec_half;
    logic [CODE_W-1:0] dec_shift;
    logic              dec_use;
    gen_state_e        nxt_state;
    logic [PH_W-1:0]   nxt_ph;
    logic [PH_W-1:0]   nxt_half;
    logic [CODE_W-1:0] nxt_shift;
    logic              nxt_use;

    audclk_cfg_decode #(
        .BASE_HI(BASE_HI), .BASE_LO(BASE_LO),
        .MCLK_MIN_HI(MCLK_MIN_HI), .MCLK_MIN_LO(MCLK_MIN_LO),
        .CODE_W(CODE_W)
    ) dec_i (
        .use_i(mclk_use_i), .sel_i(base_sel_i), .code_i(ratio_code_i),
        .legal_o(dec_legal), .last_o(dec_last), .half_o(dec_half),
        .shift_o(dec_shift), .use_o(dec_use)
    );

    audclk_seq #(
        .BASE_HI(BASE_HI), .CODE_W(CODE_W)
    ) seq_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .gate_i(gate_i),
        .legal_i(dec_legal), .last_i(dec_last), .half_i(dec_half),
        .shift_i(dec_shift), .use_i(dec_use),
        .state_d_o(nxt_state), .ph_d_o(nxt_ph), .half_d_o(nxt_half),
        .shift_d_o(nxt_shift), .use_d_o(nxt_use)
    );

    audclk_out_stage #(
        .BASE_HI(BASE_HI), .CODE_W(CODE_W), .BCLK_DIV(BCLK_DIV)
    ) out_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .state_d_i(nxt_state), .ph_d_i(nxt_ph), .half_d_i(nxt_half),
        .shift_d_i(nxt_shift), .use_d_i(nxt_use),
        .mclk_en_o(mclk_en_o), .bclk_en_o(bclk_en_o),
        .lrclk_o(lrclk_o), .cfg_err_o(cfg_err_o)
    );

endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic run_i,
    input logic gate_i,
    input logic mclk_en_o,
    input logic bclk_en_o,
    input logic lrclk_o,
    input logic cfg_err_o
);

    // R6: bit-clock pulses are never adjacent
    a_r6_bclk_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bclk_en_o |=> !bclk_en_o);

    // R2: the frame clock rises only on a bit-clock phase
    a_r2_lr_rise_on_bclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lrclk_o) |-> bclk_en_o);

    // R9: a sampled gate silences every clock output next cycle
    a_r9_gate_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_i |=> (!mclk_en_o && !bclk_en_o && !lrclk_o));

    // R5: in fault, no clock output is active
    a_r5_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (!mclk_en_o && !bclk_en_o && !lrclk_o));

    // R5: fault is entered only under a run request with the gate clear
    a_r5_fault_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cfg_err_o) |-> ($past(run_i) && !$past(gate_i)));

endmodule

bind audclk_gen audclk_gen_chk chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .gate_i(gate_i),
    .mclk_en_o(mclk_en_o), .bclk_en_o(bclk_en_o),
    .lrclk_o(lrclk_o), .cfg_err_o(cfg_err_o)
);

// File: tb/audclk_gen_tb_top.sv
`timescale 1ns/1ps
module audclk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0, gate_i = 1'b0, use_i = 1'b0, sel_i = 1'b0;
    logic [2:0] code_i = 3'd0;
    logic       mclk_en_o, bclk_en_o, lrclk_o, cfg_err_o;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int m_st = 0, m_ph = 0, m_last = 511, m_half = 256, m_shift = 0;
    bit m_use = 1'b0;
    int c_m = 0, c_b = 0, c_l = 0;
    logic prev_l = 1'b0;

    always #2.5 clk = ~clk;

    audclk_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run_i), .gate_i(gate_i),
        .mclk_use_i(use_i), .base_sel_i(sel_i), .ratio_code_i(code_i),
        .mclk_en_o(mclk_en_o), .bclk_en_o(bclk_en_o),
        .lrclk_o(lrclk_o), .cfg_err_o(cfg_err_o)
    );

    function automatic bit legal_f(bit u, bit s, int c);
        if (!u) return 1'b1;
        return s ? (c <= 3) : (c <= 4);
    endfunction

    function automatic int last_f(bit u, bit s);
        return (u && s) ? 383 : 511;
    endfunction

    task automatic load_cfg();
        m_use   = use_i;
        m_last  = last_f(use_i, sel_i);
        m_half  = (m_last + 1) / 2;
        m_shift = use_i ? int'(code_i) : 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ph = 0;
        end else begin
            case (m_st)
                0: begin
                    m_ph = 0;
                    if (run_i && !gate_i) begin
                        if (legal_f(use_i, sel_i, int'(code_i))) begin m_st = 1; load_cfg(); end
                        else m_st = 3;
                    end
                end
                1, 2: begin
                    if (gate_i) begin m_st = 0; m_ph = 0; end
                    else if (m_ph == m_last) begin
                        m_ph = 0;
                        if (!run_i) m_st = 0;
                        else if (!legal_f(use_i, sel_i, int'(code_i))) m_st = 3;
                        else begin m_st = 1; load_cfg(); end
                    end else begin
                        m_ph = m_ph + 1;
                        m_st = run_i ? 1 : 2;
                    end
                end
                default: if (!run_i || gate_i) m_st = 0;
            endcase
        end
    end

    function automatic logic e_act();
        return (m_st == 1) || (m_st == 2);
    endfunction

    task automatic chk(string req, logic act, logic exp, string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr();
        c_m = 0; c_b = 0; c_l = 0;
    endtask

    // sample every cycle at the falling edge against the model
    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R4", mclk_en_o, e_act() && m_use && ((m_ph % (1 << m_shift)) == 0), "mclk_en");
            chk("R6", bclk_en_o, e_act() && ((m_ph % 8) == 0), "bclk_en");
            chk("R2", lrclk_o, e_act() && (m_ph >= m_half), "lrclk");
            chk("R5", cfg_err_o, logic'(m_st == 3), "cfg_err");
            if (mclk_en_o) c_m++;
            if (bclk_en_o) c_b++;
            if (lrclk_o && !prev_l) c_l++;
            prev_l = lrclk_o;
        end
    endtask

    task automatic to_idle();
        run_i = 1'b0; gate_i = 1'b1;
        step(1);
        gate_i = 1'b0;
    endtask

    task automatic start(bit u, bit s, int c);
        use_i = u; sel_i = s; code_i = 3'(c); run_i = 1'b1;
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): got unfinished run, expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'h5eed_a0d1));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", mclk_en_o, 1'b0, "mclk in reset");
        chk("R1", bclk_en_o, 1'b0, "bclk in reset");
        chk("R1", lrclk_o, 1'b0, "lrclk in reset");
        chk("R1", cfg_err_o, 1'b0, "err in reset");
        rst_n = 1'b1;
        step(2);
        chk("R1", bclk_en_o | mclk_en_o | lrclk_o | cfg_err_o, 1'b0, "outputs after reset");

        // R2, R4, R6, R7: every legal code in both families
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c <= (s ? 3 : 4); c++) begin
                base = s ? 384 : 512;
                to_idle();
                start(1'b1, s[0], c);
                clr();
                step(1);
                chk("R7", bclk_en_o, 1'b1, "bclk at first cycle");
                chk("R7", mclk_en_o, 1'b1, "mclk at first cycle");
                chk("R7", lrclk_o, 1'b0, "lrclk at first cycle");
                step(base - 1);
                chk_int("R4", c_m, base >> c, "mclk pulses per frame");
                chk_int("R6", c_b, base / 8, "bclk pulses per frame");
                chk_int("R2", c_l, 1, "lrclk rises per frame");
            end
        end

        // R3: no master clock, 384 select and bad code ignored
        to_idle();
        start(1'b0, 1'b1, 7);
        clr();
        step(512);
        chk_int("R3", c_m, 0, "mclk pulses when unused");
        chk_int("R3", c_b, 64, "bclk pulses with forced 512 base");
        chk("R3", cfg_err_o, 1'b0, "no error when unused");

        // R5: illegal codes in each family
        to_idle();
        start(1'b1, 1'b1, 4);
        step(1);
        chk("R5", cfg_err_o, 1'b1, "fault on 384 code 4");
        chk("R5", bclk_en_o, 1'b0, "bclk low in fault");
        step(20);
        run_i = 1'b0;
        step(1);
        chk("R5", cfg_err_o, 1'b0, "fault left on run drop");
        start(1'b1, 1'b0, 5);
        step(3);
        chk("R5", cfg_err_o, 1'b1, "fault on 512 code 5");

        // R8: drain to frame end
        to_idle();
        start(1'b1, 1'b0, 2);
        step(100);
        run_i = 1'b0;
        clr();
        step(412);
        chk_int("R8", c_b, 51, "bclk pulses while draining");
        chk_int("R8", c_l, 1, "lrclk rise while draining");
        step(1);
        chk("R8", bclk_en_o | lrclk_o | mclk_en_o, 1'b0, "quiet after drain");
        // R8: run returns during drain
        start(1'b1, 1'b0, 2);
        step(100);
        run_i = 1'b0;
        step(50);
        run_i = 1'b1;
        step(362);
        step(1);
        chk("R8", bclk_en_o, 1'b1, "next frame after resumed drain");

        // R9: hard gate mid frame, restart at phase 0
        to_idle();
        start(1'b1, 1'b0, 0);
        step(300);
        gate_i = 1'b1;
        step(1);
        chk("R9", mclk_en_o | bclk_en_o | lrclk_o, 1'b0, "outputs after gate");
        gate_i = 1'b0;
        step(1);
        chk("R9", bclk_en_o, 1'b1, "restart at phase 0");
        chk("R9", lrclk_o, 1'b0, "restart lrclk low");

        // R10: config change applies at frame boundary only
        to_idle();
        start(1'b1, 1'b0, 0);
        step(10);
        code_i = 3'd4;
        clr();
        step(502);
        chk_int("R10", c_m, 502, "old ratio kept until boundary");
        clr();
        step(512);
        chk_int("R10", c_m, 32, "new ratio after boundary");
        code_i = 3'd5;
        step(1);
        chk("R10", cfg_err_o, 1'b1, "illegal code at boundary faults");

        // random phase
        to_idle();
        for (int i = 0; i < 60; i++) begin
            use_i  = 1'($urandom % 2);
            sel_i  = 1'($urandom % 2);
            code_i = 3'($urandom % 8);
            run_i  = ($urandom % 4) != 0;
            gate_i = ($urandom % 10) == 0;
            step(1 + int'($urandom % 700));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule